// File: doc/BRIEF.md
# Per-Port Idle Power-Down Controller

This controller manages power for four line ports. Each port has a signal-detect input from its receiver front end. When that input stays low for a programmable idle time (2.5 s of reference clock by default), the controller clears the port's enable output so that the transceiver can shut down. As soon as signal detect goes high again, the enable returns and the port's idle timer restarts from zero.

A 2-bit strap input selects which ports may use power saving. A port without power saving keeps its enable high and its timer cleared. The strap is registered on every clock, so a change reaches the ports one cycle later. The idle time is computed from the reference clock frequency and a timeout given in tenths of a second. A simulation can therefore shorten it by lowering the frequency parameter.

The signal-detect inputs are assumed to be synchronous to the reference clock. A synchronous active-low reset brings every port back to the enabled state and clears every timer.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: While reset is sampled low at a clock edge, every bit of `pwr_en` reads 1 after that edge. Every idle timer is cleared, so after reset a port again needs a full timeout before it powers down.
- R2: On a port with power saving allowed, `pwr_en[i]` goes to 0 at the TIMEOUT_CYC-th consecutive edge at which `sig_det[i]` is sampled low and the port is allowed. It stays 1 at all earlier edges.
- R3: An edge that samples `sig_det[i]` high sets `pwr_en[i]` to 1 after that edge. It also restarts the port's idle count, so a new full run of TIMEOUT_CYC low edges is needed.
- R4: Strap value 2'b00 allows power saving on no port, so all enables stay 1 however long signal detect is low.
- R5: Strap value 2'b01 allows power saving on ports 1, 2 and 3 and not on port 0.
- R6: Strap value 2'b10 allows power saving on ports 0, 1 and 2 and not on port 3.
- R7: Strap value 2'b11 allows power saving on all four ports.
- R8: The strap is registered every cycle, and a port acts on a new strap value from the second edge after the change. A port that becomes disallowed is enabled again at that edge and its timer is held at zero. A port that becomes allowed starts counting at that edge.
- R9: Each port has its own timer and enable, so activity on one port does not change the enable or the timing of another.
- R10: TIMEOUT_CYC equals CLK_HZ × TIMEOUT_TENTHS / 10 clock cycles. The default values (25 MHz, 25 tenths) give 2.5 s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 2 | Power-saving port selection code |
| sig_det | input | 4 | Per-port signal detect, high when a signal is present |
| pwr_en | output | 4 | Per-port transceiver enable, high when powered |

## Verification
Two events can land on the same edge: a timer reaching its limit, and a strap change taking effect or a signal-detect pulse arriving. The bench sends a one-cycle detect pulse on one port while the other ports are still counting. It then checks that only the pulsed port's timeout moves, by exactly the pulse offset. Strap codes are switched while ports are already powered down and signal detect is held low. The enables are compared edge by edge against expected values worked out from the one-cycle strap lag. This covers both a disallowed port waking up and a newly allowed port counting its first edge.

// File: rtl/pwrsave_pkg.sv
// Package: shared constants and types for the idle power-down controller.
// Assumes exactly four ports, because the strap decode is defined for four.
package pwrsave_pkg;

    localparam int NPORT = 4;

    typedef logic [NPORT-1:0] port_vec_t;

    // Strap codes, named by the set of ports allowed to power down.
    typedef enum logic [1:0] {
        STRAP_NONE    = 2'b00,
        STRAP_NO_P0   = 2'b01,
        STRAP_NO_P3   = 2'b10,
        STRAP_ALL     = 2'b11
    } strap_code_t;

endpackage

// File: rtl/idle_strap_decode.sv
// Module: registers the strap input and turns it into a per-port allow mask.
// Assumes: strap is static or slowly changing; a change is seen one clock later.
module idle_strap_decode
    import pwrsave_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap,
    output port_vec_t  allow
);

    port_vec_t allow_next;

    // Purpose: map the strap code to the ports that may power down.
    always_comb begin
        unique case (strap_code_t'(strap))
            STRAP_NONE:  allow_next = 4'b0000;
            STRAP_NO_P0: allow_next = 4'b1110;
            STRAP_NO_P3: allow_next = 4'b0111;
            STRAP_ALL:   allow_next = 4'b1111;
            default:     allow_next = 4'b0000;
        endcase
    end

    // Purpose: hold the decoded mask; reset leaves all ports disallowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allow <= '0;
        end else begin
            allow <= allow_next;
        end
    end

    AST_STRAP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && strap == 2'b00) |=> (allow == 4'b0000)); // R4
    AST_STRAP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && strap == 2'b11) |=> (allow == 4'b1111)); // R7
    AST_STRAP_P0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && strap == 2'b01) |=> (!allow[0] && $countones(allow) == 3)); // R5
    AST_STRAP_P3_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && strap == 2'b10) |=> (!allow[3] && $countones(allow) == 3)); // R6

endmodule

// File: rtl/idle_port_timer.sv
// Module: idle timer and enable flag for one port.
// Assumes: sig_det is synchronous to clk; TIMEOUT_CYC is at least 2.
// The enable drops at the TIMEOUT_CYC-th consecutive allowed low edge.
module idle_port_timer #(
    parameter longint TIMEOUT_CYC = 100,
    parameter int     CNT_W       = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic sig_det,
    output logic pwr_en
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] idle_cnt;
    logic             at_limit;

    // Purpose: flag the cycle in which this edge would complete the timeout.
    always_comb begin
        at_limit = (idle_cnt == LAST);
    end

    // Purpose: count idle edges, power down at the limit, wake on detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            pwr_en   <= 1'b1;
        end else if (sig_det || !allow) begin
            idle_cnt <= '0;
            pwr_en   <= 1'b1;
        end else if (pwr_en) begin
            if (at_limit) begin
                pwr_en <= 1'b0;
            end else begin
                idle_cnt <= idle_cnt + CNT_W'(1);
            end
        end
    end

    AST_RESET_ON: assert property (@(posedge clk)
        !rst_n |=> (pwr_en && idle_cnt == '0)); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST); // R2
    AST_FALL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> ($past(idle_cnt) == LAST)); // R2
    AST_DET_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sig_det) |=> (pwr_en && idle_cnt == '0)); // R3
    AST_NOSAVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !allow) |=> pwr_en); // R8

endmodule

// File: rtl/idle_pwr_ctrl.sv
// Module: top of the four-port idle power-down controller.
// Assumes: sig_det is already synchronous to clk; the strap may change at any time.
// The timeout in cycles comes from CLK_HZ and TIMEOUT_TENTHS (R10).
module idle_pwr_ctrl
    import pwrsave_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 25_000_000,
    parameter int unsigned TIMEOUT_TENTHS = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap,
    input  logic [3:0] sig_det,
    output logic [3:0] pwr_en
);

    localparam longint TIMEOUT_CYC = (longint'(CLK_HZ) * longint'(TIMEOUT_TENTHS)) / 10;
    localparam int     CNT_W       = $clog2(TIMEOUT_CYC);

    port_vec_t allow;

    idle_strap_decode u_strap (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (strap),
        .allow (allow)
    );

    // One independent timer per port (R9).
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        idle_port_timer #(
            .TIMEOUT_CYC (TIMEOUT_CYC),
            .CNT_W       (CNT_W)
        ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .allow   (allow[p]),
            .sig_det (sig_det[p]),
            .pwr_en  (pwr_en[p])
        );
    end

    AST_DISALLOWED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && strap == 2'b00) |=> ##1 (pwr_en == 4'b1111)); // R4

endmodule

// File: tb/idle_pwr_ctrl_tb_top.sv
// Bench: a scoreboard queue of expected enable vectors, each keyed by an edge count.
module idle_pwr_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  T          = 100;   // CLK_HZ=40, 25 tenths -> 100 cycles (R10)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b11;
    logic [3:0] sig_det = 4'hF;
    logic [3:0] pwr_en;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] exp;
        string      req;
    } item_t;

    item_t q[$];

    idle_pwr_ctrl #(.CLK_HZ(40), .TIMEOUT_TENTHS(25)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap   (strap),
        .sig_det (sig_det),
        .pwr_en  (pwr_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver helper: expect pwr_en == e just after the dly-th coming edge.
    task automatic expect_at(int dly, logic [3:0] e, string req);
        item_t it;
        int pos;
        it.at = cyc + dly; it.exp = e; it.req = req;
        pos = q.size();
        for (int k = 0; k < q.size(); k++) begin
            if (q[k].at > it.at) begin pos = k; break; end
        end
        q.insert(pos, it);
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops due items one step after each edge and compares.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (q.size() > 0 && q[0].at <= cyc) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (it.at != cyc || pwr_en !== it.exp) begin
                    bad++;
                    $display("FAIL %s cycle %0d: pwr_en=%b expected=%b", it.req, it.at, pwr_en, it.exp);
                end
            end
        end
    end

    // Watchdog: counts as one failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        expect_at(2, 4'hF, "R1");               // enables high during reset
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(3);

        // R2 R7 R10: all ports allowed, all idle -> drop at edge T
        sig_det = 4'h0;
        expect_at(T-1, 4'hF, "R2");
        expect_at(T,   4'h0, "R10");
        wait_neg(T+1);

        // R3 R9: wake port 2 only, then idle it again for a full timeout
        sig_det = 4'b0100;
        expect_at(1, 4'b0100, "R3");
        wait_neg(1);
        sig_det = 4'h0;
        expect_at(T-1, 4'b0100, "R3");
        expect_at(T,   4'b0000, "R2");
        wait_neg(T+1);

        // R3 R9: one-cycle detect pulse on port 1 in the middle of the count
        sig_det = 4'hF;
        wait_neg(2);
        sig_det = 4'h0;
        expect_at(T-1,  4'hF,    "R9");
        expect_at(T,    4'b0010, "R9");
        expect_at(T+60, 4'b0010, "R3");
        expect_at(T+61, 4'b0000, "R3");
        wait_neg(60);
        sig_det = 4'b0010;
        wait_neg(1);
        sig_det = 4'h0;
        wait_neg(T+5);

        // R4: strap 00 -> nothing powers down
        sig_det = 4'hF;
        wait_neg(2);
        strap = 2'b00;
        sig_det = 4'h0;
        expect_at(T+50, 4'hF, "R4");
        wait_neg(T+51);

        // R5 R8: strap 01, first edge still uses 00
        strap = 2'b01;
        expect_at(T,   4'hF,    "R8");
        expect_at(T+1, 4'b0001, "R5");
        wait_neg(T+2);

        // R6 R8: strap 10, port 3 wakes at second edge, port 0 counts from it
        strap = 2'b10;
        expect_at(1,   4'b0001, "R8");
        expect_at(2,   4'b1001, "R8");
        expect_at(T,   4'b1001, "R6");
        expect_at(T+1, 4'b1000, "R6");
        wait_neg(T+2);

        // R7: strap 11 again, port 3 counts from the second edge
        strap = 2'b11;
        expect_at(T,   4'b1000, "R7");
        expect_at(T+1, 4'b0000, "R7");
        wait_neg(T+2);

        // R1: reset in operation re-enables and clears timers
        rst_n = 1'b0;
        expect_at(1, 4'hF, "R1");
        wait_neg(2);
        rst_n = 1'b1;
        expect_at(T,   4'hF, "R1");
        expect_at(T+1, 4'h0, "R1");
        wait_neg(T+3);

        while (q.size() > 0) wait_neg(1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule